// File: doc/BRIEF.md
# Sampling Event Counter Bank

The block keeps one down-counter for each of four profiled event kinds: retired instructions, retired branches, data-cache misses, and software value-sample operations. Each counter is armed with its own sampling interval. Every qualifying event moves its counter one step closer to underflow. On underflow the counter posts a sample record request and reloads. The request carries the event kind, the address of the instruction that caused the underflow, and a data word that depends on the kind.

Branch and cache-miss strobes pass through attribute filters before they are counted. When a reload is randomized, a chosen number of low interval bits is replaced with bits from a free-running 16-bit LFSR. This keeps the sampling from locking onto loops of fixed length.

Records leave the block through a valid/ready handshake. Each counter has one pending slot. An underflow that finds its slot still occupied is not queued: it only increments a saturating missed-sample count for that counter.

Top module: `sampling_event_bank`

## Requirements
- R1: While reset is asserted and right after it is released, `rec_valid` is 0, every missed-sample count is 0, and no counter is armed.
- R2: A rising edge of a counter's enable loads its stored interval. No event is counted in that cycle. After that, each qualifying event decrements the counter. An event that finds the counter at 1 or 0 is an underflow: it posts one record request and reloads the counter. With no randomization, an interval of N therefore gives one sample every N events.
- R3: The reload keeps the interval's upper bits and takes its low k bits from the LFSR, where k is the counter's randomize field, limited to 8. The LFSR is seeded with 0xACE1 at reset and steps on every cycle. Each step shifts it left and feeds bit 15 ^ bit 13 ^ bit 12 ^ bit 10 into bit 0. A reload uses the LFSR value present in the cycle of the underflow.
- R4: A record holds a type code, the triggering instruction address, and a data word. The type codes are 0 for instruction, 1 for branch, 2 for cache miss and 3 for value sample. The data word is 0 for an instruction, the branch target for a branch, the miss address for a cache miss, and the software operand for a value sample.
- R5: The branch filter has four bits: bit 0 accepts direct branches, bit 1 accepts indirect branches, bit 2 accepts conditional branches and bit 3 accepts unconditional branches. A branch is counted only if it passes both its direct/indirect bit and its conditional/unconditional bit.
- R6: A cache miss is counted only when its 2-bit level is greater than or equal to bits [1:0] of the cache-miss counter's filter.
- R7: A counter whose enable is low ignores its events, including value-sample operations. It creates no record and does not change its missed-sample count.
- R8: `rec_valid` stays high until `rec_ready` accepts the record. When several slots are pending, the lowest type code is presented first. An accepted slot is empty in the next cycle.
- R9: An underflow whose slot is already pending leaves that slot's contents unchanged. Instead, it increments that counter's missed-sample count, which saturates at all ones.
- R10: A configuration write to a counter takes effect only while that counter's enable is low. Writes made while it is enabled are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Counter addressed by the write (type code) |
| cfg_interval | input | CNT_W | Sampling interval |
| cfg_rand | input | 4 | Number of low reload bits to randomize |
| cfg_filter | input | 4 | Attribute filter (branch / cache-miss counters) |
| cnt_en | input | 4 | Per-counter enable, indexed by type code |
| instr_v | input | 1 | Instruction retired strobe |
| instr_pc | input | ADDR_W | Address of the retired instruction |
| br_v | input | 1 | Branch retired strobe |
| br_pc | input | ADDR_W | Branch instruction address |
| br_target | input | ADDR_W | Branch target address |
| br_indirect | input | 1 | Branch is indirect |
| br_cond | input | 1 | Branch is conditional |
| dc_v | input | 1 | Data-cache miss strobe |
| dc_pc | input | ADDR_W | Address of the missing instruction |
| dc_addr | input | DATA_W | Data address that missed |
| dc_level | input | 2 | Cache level of the miss |
| val_v | input | 1 | Software value-sample strobe |
| val_pc | input | ADDR_W | Address of the value-sample operation |
| val_data | input | DATA_W | Software operand |
| rec_valid | output | 1 | Record request valid |
| rec_ready | input | 1 | Record request accepted |
| rec_type | output | 2 | Record type code |
| rec_pc | output | ADDR_W | Triggering instruction address |
| rec_data | output | DATA_W | Event-specific data |
| miss_cnt | output | 4*MISS_W | Missed-sample counts, MISS_W bits per counter |

## Verification
The bench builds the block with an 8-bit interval, 16-bit addresses and data, and 3-bit missed-sample counts. With an 8-bit interval, a randomize field of 8 replaces the entire reload. Randomized reloads can then fall to 0 or 1, which exercises the case of an underflow on the very next event. The short miss counter saturates after seven lost samples, so holding `rec_ready` low for a few hundred cycles pushes every counter into saturation and keeps it there.

// File: rtl/evsamp_pkg.sv
package evsamp_pkg;
  localparam int NUM_EV   = 4;
  localparam int TYPE_W   = 2;
  localparam int LFSR_W   = 16;
  localparam int RAND_W   = 4;
  localparam int FILT_W   = 4;
  localparam int RAND_MAX = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [TYPE_W-1:0] {
    EV_INSTR  = 2'd0,
    EV_BRANCH = 2'd1,
    EV_DMISS  = 2'd2,
    EV_VALUE  = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/evsamp_lfsr.sv
module evsamp_lfsr
  import evsamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    state_d = {state[LFSR_W-2:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= state_d;
  end

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/evsamp_qualify.sv
module evsamp_qualify
  import evsamp_pkg::*;
(
  input  logic              instr_v,
  input  logic              br_v,
  input  logic              br_indirect,
  input  logic              br_cond,
  input  logic              dc_v,
  input  logic [1:0]        dc_level,
  input  logic              val_v,
  input  logic [FILT_W-1:0] br_filt,
  input  logic [FILT_W-1:0] dc_filt,
  output logic [NUM_EV-1:0] hit
);
  logic br_kind_ok;
  logic br_cond_ok;
  logic dc_level_ok;

  always_comb begin
    br_kind_ok  = br_indirect ? br_filt[1] : br_filt[0];
    br_cond_ok  = br_cond     ? br_filt[2] : br_filt[3];
    dc_level_ok = (dc_level >= dc_filt[1:0]);
    hit         = '0;
    hit[EV_INSTR]  = instr_v;
    hit[EV_BRANCH] = br_v & br_kind_ok & br_cond_ok;
    hit[EV_DMISS]  = dc_v & dc_level_ok;
    hit[EV_VALUE]  = val_v;
  end
endmodule

// File: rtl/evsamp_counter.sv
module evsamp_counter
  import evsamp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic [RAND_W-1:0] cfg_rand,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_pc,
  input  logic [DATA_W-1:0] hit_data,
  input  logic [LFSR_W-1:0] lfsr,
  input  logic              take,
  output logic [FILT_W-1:0] filt_q,
  output logic              pend_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] data_q,
  output logic [MISS_W-1:0] miss_q
);
  localparam logic [RAND_W-1:0] RAND_LIM = RAND_W'(RAND_MAX);

  logic              en_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, reload, rmask, rbits;
  logic [CNT_W-1:0]  interval_q;
  logic [RAND_W-1:0] rand_q, rand_k;
  logic              load, step, fire, cap, cnt_ce, cfg_ce, miss_ce, pend_d;
  logic [MISS_W-1:0] miss_d;

  always_comb begin
    rand_k = (rand_q > RAND_LIM) ? RAND_LIM : rand_q;
    for (int i = 0; i < CNT_W; i++) begin
      rmask[i] = (i < int'(rand_k));
      rbits[i] = lfsr[i % LFSR_W];
    end
    reload = (interval_q & ~rmask) | (rbits & rmask);
  end

  always_comb begin
    load    = en & ~en_q;
    step    = en & ~load & hit;
    fire    = step & (cnt_q <= CNT_W'(1));
    cap     = fire & ~pend_q;
    cnt_ce  = load | step;
    cnt_d   = load ? interval_q : (fire ? reload : cnt_q - 1'b1);
    cfg_ce  = cfg_we & ~en;
    pend_d  = cap | (pend_q & ~take);
    miss_ce = fire & pend_q & ~(&miss_q);
    miss_d  = miss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      miss_q     <= '0;
      interval_q <= '0;
      rand_q     <= '0;
      filt_q     <= '0;
    end else begin
      en_q   <= en;
      pend_q <= pend_d;
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (miss_ce) miss_q <= miss_d;
      if (cfg_ce) begin
        interval_q <= cfg_interval;
        rand_q     <= cfg_rand;
        filt_q     <= cfg_filter;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      pc_q   <= hit_pc;
      data_q <= hit_data;
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(interval_q));
  // R9
  miss_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (miss_q >= $past(miss_q)));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pend_q) |=> !pend_q);
  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> (pend_q && $stable(pc_q) && $stable(data_q)));
endmodule

// File: rtl/evsamp_arbiter.sv
module evsamp_arbiter
  import evsamp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_EV-1:0]             pend,
  input  logic [NUM_EV-1:0][ADDR_W-1:0] pc,
  input  logic [NUM_EV-1:0][DATA_W-1:0] data,
  input  logic                          rec_ready,
  output logic                          rec_valid,
  output logic [TYPE_W-1:0]             rec_type,
  output logic [ADDR_W-1:0]             rec_pc,
  output logic [DATA_W-1:0]             rec_data,
  output logic [NUM_EV-1:0]             take
);
  always_comb begin
    rec_type = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (pend[i]) rec_type = TYPE_W'(i);
    end
    rec_valid = |pend;
    rec_pc    = pc[rec_type];
    rec_data  = data[rec_type];
    take      = '0;
    if (rec_valid && rec_ready) take[rec_type] = 1'b1;
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(take));
  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> rec_valid);
endmodule

// File: rtl/sampling_event_bank.sv
module sampling_event_bank
  import evsamp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MISS_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [CNT_W-1:0]         cfg_interval,
  input  logic [3:0]               cfg_rand,
  input  logic [3:0]               cfg_filter,
  input  logic [3:0]               cnt_en,
  input  logic                     instr_v,
  input  logic [ADDR_W-1:0]        instr_pc,
  input  logic                     br_v,
  input  logic [ADDR_W-1:0]        br_pc,
  input  logic [ADDR_W-1:0]        br_target,
  input  logic                     br_indirect,
  input  logic                     br_cond,
  input  logic                     dc_v,
  input  logic [ADDR_W-1:0]        dc_pc,
  input  logic [DATA_W-1:0]        dc_addr,
  input  logic [1:0]               dc_level,
  input  logic                     val_v,
  input  logic [ADDR_W-1:0]        val_pc,
  input  logic [DATA_W-1:0]        val_data,
  output logic                     rec_valid,
  input  logic                     rec_ready,
  output logic [1:0]               rec_type,
  output logic [ADDR_W-1:0]        rec_pc,
  output logic [DATA_W-1:0]        rec_data,
  output logic [4*MISS_W-1:0]      miss_cnt
);
  logic [LFSR_W-1:0]              lfsr;
  logic [NUM_EV-1:0]              hit, pend, take;
  logic [NUM_EV-1:0][ADDR_W-1:0]  ev_pc, slot_pc;
  logic [NUM_EV-1:0][DATA_W-1:0]  ev_data, slot_data;
  logic [NUM_EV-1:0][FILT_W-1:0]  filt;
  logic [NUM_EV-1:0][MISS_W-1:0]  miss;

  always_comb begin
    ev_pc[EV_INSTR]    = instr_pc;
    ev_data[EV_INSTR]  = '0;
    ev_pc[EV_BRANCH]   = br_pc;
    ev_data[EV_BRANCH] = DATA_W'(br_target);
    ev_pc[EV_DMISS]    = dc_pc;
    ev_data[EV_DMISS]  = dc_addr;
    ev_pc[EV_VALUE]    = val_pc;
    ev_data[EV_VALUE]  = val_data;
  end

  evsamp_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr));

  evsamp_qualify u_qual (
    .instr_v(instr_v), .br_v(br_v), .br_indirect(br_indirect), .br_cond(br_cond),
    .dc_v(dc_v), .dc_level(dc_level), .val_v(val_v),
    .br_filt(filt[EV_BRANCH]), .dc_filt(filt[EV_DMISS]), .hit(hit)
  );

  for (genvar e = 0; e < NUM_EV; e++) begin : g_cnt
    evsamp_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MISS_W(MISS_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en[e]),
      .cfg_we(cfg_we && (cfg_sel == TYPE_W'(e))),
      .cfg_interval(cfg_interval), .cfg_rand(cfg_rand), .cfg_filter(cfg_filter),
      .hit(hit[e]), .hit_pc(ev_pc[e]), .hit_data(ev_data[e]),
      .lfsr(lfsr), .take(take[e]),
      .filt_q(filt[e]), .pend_q(pend[e]), .pc_q(slot_pc[e]),
      .data_q(slot_data[e]), .miss_q(miss[e])
    );
    assign miss_cnt[e*MISS_W +: MISS_W] = miss[e];
  end

  evsamp_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .pc(slot_pc), .data(slot_data),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_type(rec_type),
    .rec_pc(rec_pc), .rec_data(rec_data), .take(take)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!rec_valid && miss_cnt == '0));
endmodule

// File: tb/test_sampling_event_bank.sv
module test_sampling_event_bank;
  localparam int CW = 8, AW = 16, DW = 16, MW = 3;
  localparam int MSAT = (1 << MW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [CW-1:0] cfg_interval;
  logic [3:0] cfg_rand, cfg_filter, cnt_en;
  logic instr_v, br_v, br_indirect, br_cond, dc_v, val_v, rec_ready;
  logic [AW-1:0] instr_pc, br_pc, br_target, dc_pc, val_pc;
  logic [DW-1:0] dc_addr, val_data;
  logic [1:0] dc_level;
  logic rec_valid;
  logic [1:0] rec_type;
  logic [AW-1:0] rec_pc;
  logic [DW-1:0] rec_data;
  logic [4*MW-1:0] miss_cnt;

  always #4 clk = ~clk;

  sampling_event_bank #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW), .MISS_W(MW)) i_sampling_event_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_interval(cfg_interval),
    .cfg_rand(cfg_rand), .cfg_filter(cfg_filter), .cnt_en(cnt_en),
    .instr_v(instr_v), .instr_pc(instr_pc), .br_v(br_v), .br_pc(br_pc), .br_target(br_target),
    .br_indirect(br_indirect), .br_cond(br_cond), .dc_v(dc_v), .dc_pc(dc_pc), .dc_addr(dc_addr),
    .dc_level(dc_level), .val_v(val_v), .val_pc(val_pc), .val_data(val_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_type(rec_type), .rec_pc(rec_pc),
    .rec_data(rec_data), .miss_cnt(miss_cnt)
  );

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cnt[4], m_int[4], m_rnd[4], m_flt[4], m_pc[4], m_dat[4], m_miss[4];
  bit m_pend[4], m_enq[4];
  bit [15:0] m_lfsr;

  function automatic int m_first();
    for (int e = 0; e < 4; e++) if (m_pend[e]) return e;
    return -1;
  endfunction

  function automatic bit m_hit(input int e);
    case (e)
      0: return instr_v;
      1: return br_v && (br_indirect ? m_flt[1][1] : m_flt[1][0]) && (br_cond ? m_flt[1][2] : m_flt[1][3]);
      2: return dc_v && (int'(dc_level) >= (m_flt[2] % 4));
      default: return val_v;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 4; e++) begin
        m_cnt[e] = 0; m_int[e] = 0; m_rnd[e] = 0; m_flt[e] = 0;
        m_pend[e] = 0; m_enq[e] = 0; m_miss[e] = 0;
      end
      m_lfsr = 16'hACE1;
    end else begin
      int acc;
      acc = (rec_ready && m_first() >= 0) ? m_first() : -1;
      for (int e = 0; e < 4; e++) begin
        bit en, rise, h, fire, oldp;
        int k, mask, rl;
        en = cnt_en[e]; rise = en && !m_enq[e]; h = m_hit(e);
        fire = en && !rise && h && (m_cnt[e] <= 1);
        oldp = m_pend[e];
        k = (m_rnd[e] > 8) ? 8 : m_rnd[e];
        mask = (1 << k) - 1;
        rl = ((m_int[e] & ~mask) | (int'(m_lfsr) & mask)) & 8'hFF;
        if (acc == e) m_pend[e] = 0;
        if (fire) begin
          if (oldp) begin
            if (m_miss[e] < MSAT) m_miss[e]++;
          end else begin
            m_pend[e] = 1;
            case (e)
              0: begin m_pc[e] = instr_pc; m_dat[e] = 0; end
              1: begin m_pc[e] = br_pc; m_dat[e] = br_target; end
              2: begin m_pc[e] = dc_pc; m_dat[e] = dc_addr; end
              default: begin m_pc[e] = val_pc; m_dat[e] = val_data; end
            endcase
          end
        end
        if (rise) m_cnt[e] = m_int[e];
        else if (en && h) m_cnt[e] = fire ? rl : m_cnt[e] - 1;
        if (cfg_we && cfg_sel == 2'(e) && !en) begin
          m_int[e] = cfg_interval; m_rnd[e] = cfg_rand; m_flt[e] = cfg_filter;
        end
        m_enq[e] = en;
      end
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int f;
      f = m_first();
      chk(rec_valid == (f >= 0), "R2/R8 valid", rec_valid, f >= 0);
      if (f >= 0 && rec_valid) begin
        chk(rec_type == 2'(f), "R8 type", rec_type, f);
        chk(rec_pc == AW'(m_pc[f]), "R4 pc", rec_pc, m_pc[f]);
        chk(rec_data == DW'(m_dat[f]), "R4/R3 data", rec_data, m_dat[f]);
      end
      for (int e = 0; e < 4; e++)
        chk(miss_cnt[e*MW +: MW] == MW'(m_miss[e]), "R9 missed", miss_cnt[e*MW +: MW], m_miss[e]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic quiet();
    instr_v = 0; br_v = 0; dc_v = 0; val_v = 0;
  endtask

  task automatic cfg(input int sel, input int iv, input int rn, input int fl);
    @(posedge clk); #2;
    cfg_we = 1; cfg_sel = 2'(sel); cfg_interval = CW'(iv); cfg_rand = 4'(rn); cfg_filter = 4'(fl);
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic run(input int n, input int ready_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      instr_v = ($urandom_range(99) < 50); instr_pc = AW'($urandom);
      br_v = ($urandom_range(99) < 35); br_pc = AW'($urandom); br_target = AW'($urandom);
      br_indirect = $urandom_range(1); br_cond = $urandom_range(1);
      dc_v = ($urandom_range(99) < 25); dc_pc = AW'($urandom); dc_addr = DW'($urandom);
      dc_level = 2'($urandom_range(3));
      val_v = ($urandom_range(99) < 20); val_pc = AW'($urandom); val_data = DW'($urandom);
      rec_ready = ($urandom_range(99) < ready_pct);
    end
    @(posedge clk); #2; quiet();
  endtask

  task automatic drain();
    @(posedge clk); #2; quiet(); rec_ready = 1;
    repeat (8) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_interval = 0; cfg_rand = 0; cfg_filter = 0;
    cnt_en = 0; rec_ready = 0; quiet();
    br_indirect = 0; br_cond = 0; dc_level = 0;
    instr_pc = 0; br_pc = 0; br_target = 0; dc_pc = 0; dc_addr = 0; val_pc = 0; val_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rec_valid == 0, "R1 valid in reset", rec_valid, 0);
    chk(miss_cnt == 0, "R1 miss in reset", miss_cnt, 0);
    @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    chk(rec_valid == 0, "R1 valid after reset", rec_valid, 0);

    // R10 and R2 directed: interval 3, rewrite to 1 while enabled is dropped
    cfg(0, 3, 0, 0);
    @(posedge clk); #2; cnt_en = 4'b0001;
    cfg(0, 1, 0, 0);
    rec_ready = 0;
    @(posedge clk); #2; instr_v = 1; instr_pc = 16'h1234;
    @(posedge clk); #2; instr_pc = 16'h1238;
    @(posedge clk); #2; instr_v = 0;
    @(negedge clk);
    chk(rec_valid == 0, "R10 write while enabled dropped", rec_valid, 0);
    @(posedge clk); #2; instr_v = 1; instr_pc = 16'h4444;
    @(posedge clk); #2; instr_v = 0;
    @(negedge clk);
    chk(rec_valid == 1, "R2 third event underflows", rec_valid, 1);
    chk(rec_pc == 16'h4444, "R4 pc of third event", rec_pc, 16'h4444);
    drain();

    // phase A: plain intervals, all filters open (R5, R6)
    @(posedge clk); #2; cnt_en = 0;
    cfg(0, 3, 0, 0); cfg(1, 4, 0, 4'hF); cfg(2, 2, 0, 0); cfg(3, 5, 0, 0);
    @(posedge clk); #2; cnt_en = 4'hF;
    run(600, 70);
    drain();

    // phase B: randomized reloads (R3), restrictive filters (R5, R6)
    @(posedge clk); #2; cnt_en = 0;
    cfg(0, 20, 3, 0); cfg(1, 6, 8, 4'b0101); cfg(2, 3, 2, 2); cfg(3, 9, 12, 0);
    @(posedge clk); #2; cnt_en = 4'hF;
    run(400, 60);
    cfg(1, 2, 0, 4'hF);  // R10: dropped, counter enabled
    run(400, 60);
    // phase C: no acceptance, missed counts saturate (R9)
    run(300, 0);
    drain();

    // phase D: value counter disabled (R7)
    @(posedge clk); #2; cnt_en = 4'b0111;
    run(300, 80);
    drain();
    @(posedge clk); #2; cnt_en = 0;
    drain();
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2; instr_v = 1; br_v = 1; dc_v = 1; val_v = 1; dc_level = 3;
      @(negedge clk);
      chk(rec_valid == 0, "R7 disabled counters ignore events", rec_valid, 0);
    end
    @(posedge clk); #2; quiet();

    // phase E: indirect-unconditional branches, level >= 3 misses (R5, R6)
    cfg(1, 3, 0, 4'b1010); cfg(2, 2, 1, 3);
    @(posedge clk); #2; cnt_en = 4'hF;
    run(500, 50);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule